// File: doc/BRIEF.md
# Triggered one-shot delay timer

The block is an idle counter that waits for a chosen trigger edge. It then counts prescaled ticks from zero up to a programmed end value, and stops by itself back at zero. The counter is 16 bits wide by default. Any of four trigger sources can be selected: either edge of the first channel input, a polarity-qualified edge of the first or second channel input, or a polarity-qualified edge of an external trigger input. Every trigger input passes through a two-flop synchronizer and an edge detector. The counter therefore starts on the second clock after an edge reaches the pin.

Four compare channels share the one end value. Each channel holds its own delay value. An armed channel raises its interrupt when the count reaches its delay, and doing so disarms the channel. Each arming therefore gives one notification. Software loads the prescaler, the end value, the delays and the control word through a simple write port. The end value written by software only takes effect when the update strobe is pulsed. That strobe can be made silent, so that only the natural end of a run raises the update flag. A mode bit makes every trigger restart the count from zero.

Top module: `oneshot_delay_timer`

## Requirements
- R1: After reset, busy_o and upd_irq_o are 0, cnt_o is 0, all cmp_irq_o bits are 0, the prescaler is 0, the active end value is 0, and trigger select 0 is in use.
- R2: The trigger source is control bits [1:0] (write address 6). Value 0 is either edge of trig_c1_i, value 1 is trig_c1_i qualified by its polarity, value 2 is trig_c2_i qualified by its polarity, and value 3 is trig_ext_i qualified by its polarity. An edge on a source that is not selected does not start the counter.
- R3: The polarity bits are control bit 2 (channel 1), bit 3 (channel 2) and bit 4 (external). A value of 0 selects the rising edge only and a value of 1 selects the falling edge only.
- R4: A pin edge that is driven before clock edge E0 sets busy_o after edge E2, with cnt_o at 0. With a prescaler of 0 and an active end value N, busy_o then stays high for N+1 cycles. The counter then stops and cnt_o holds 0 until the next start.
- R5: The prescaler (write address 0) holds P. Each count value lasts P+1 clock cycles, so a run lasts (N+1)*(P+1) cycles.
- R6: Channel i has its delay at write address 2+i. When channel i is armed and cnt_o takes the value of its delay, cmp_irq_o[i] is set in that same cycle and the arming is cleared. A delay of 0 fires when the counter starts. A channel that is not armed raises nothing, so a second run without re-arming leaves the flag at 0.
- R7: Write address 7 arms channel i when bit i is 1 and leaves the other arms unchanged. Bit 4 clears all compare flags and the update flag.
- R8: With control bit 5 at 0, a trigger that arrives while the counter is running is ignored and the run length is unchanged.
- R9: With control bit 5 at 1, every trigger clears the count to 0 and keeps counting. A run that is retriggered therefore ends N+1 ticks after the last trigger.
- R10: Writing address 1 changes only a staged end value. upd_i copies the staged value into the active end value and clears the count and the prescaler, and the counter keeps running if it was running. The strobe sets upd_irq_o only while control bit 6 is 0.
- R11: The natural end of a run sets upd_irq_o, whatever the value of control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_c1_i | input | 1 | Channel 1 trigger input |
| trig_c2_i | input | 1 | Channel 2 trigger input |
| trig_ext_i | input | 1 | External trigger input |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| upd_i | input | 1 | Software update strobe |
| cmp_irq_o | output | 4 | Per-channel compare flags |
| upd_irq_o | output | 1 | Update flag |
| busy_o | output | 1 | Counter running |
| cnt_o | output | 16 | Current count |

## Verification
The bench builds the block with its default parameters: 16-bit counter and prescaler, four channels. It then programs small end values and prescalers, which keeps runs short. That puts one-tick runs, delays of zero, delays equal to the end value and multi-cycle prescaling within a few dozen cycles each. One table walks every trigger-select and polarity combination, with edges that must start the counter and edges that must not. Directed runs measure how long a retriggered or mid-run-updated run lasts, in the plain mode and in the restart mode.

// File: rtl/oneshot_delay_timer.sv
module oneshot_delay_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int NCH   = 4,
  localparam int DW     = (CNT_W > PSC_W) ? CNT_W : PSC_W,
  localparam int ADDR_W = $clog2(NCH + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_c1_i,
  input  logic              trig_c2_i,
  input  logic              trig_ext_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              upd_i,
  output logic [NCH-1:0]    cmp_irq_o,
  output logic              upd_irq_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [ADDR_W-1:0] A_PSC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NCH + 2);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(NCH + 3);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  logic [2:0] s1, s2, s3;
  logic [2:0] rise, fall;
  logic [1:0] sel;
  logic [2:0] pol;
  logic       rmode, urs;
  logic [PSC_W-1:0] psc, pc;
  logic [CNT_W-1:0] end_sh, end_act, cnt;
  logic [CNT_W-1:0] cmp [NCH];
  logic [NCH-1:0]   ier, flag, match;
  logic running, uflag, trig_evt, start, tick, last, ovf;
  logic wr_irq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {trig_ext_i, trig_c2_i, trig_c1_i};
      s2 <= s1;
      s3 <= s2;
    end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_comb
    case (sel)
      2'd0:    trig_evt = rise[0] | fall[0];
      2'd1:    trig_evt = pol[0] ? fall[0] : rise[0];
      2'd2:    trig_evt = pol[1] ? fall[1] : rise[1];
      default: trig_evt = pol[2] ? fall[2] : rise[2];
    endcase

  assign start  = trig_evt && (!running || rmode);
  assign tick   = running && (pc == psc);
  assign last   = tick && (cnt == end_act);
  assign ovf    = last && !start && !upd_i;
  assign wr_irq = wr_en_i && (wr_addr_i == A_IRQ);

  for (genvar i = 0; i < NCH; i++) begin : g_match
    assign match[i] = (start && cmp[i] == '0) ||
                      (!start && !upd_i && tick && !last && (cnt + ONE) == cmp[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      psc <= '0; end_sh <= '0; end_act <= '0;
      sel <= '0; pol <= '0; rmode <= 1'b0; urs <= 1'b0;
      for (int i = 0; i < NCH; i++) cmp[i] <= '0;
    end else begin
      if (wr_en_i) begin
        if (wr_addr_i == A_PSC) psc <= wr_data_i[PSC_W-1:0];
        if (wr_addr_i == A_END) end_sh <= wr_data_i[CNT_W-1:0];
        if (wr_addr_i == A_CTRL) begin
          sel   <= wr_data_i[1:0];
          pol   <= wr_data_i[4:2];
          rmode <= wr_data_i[5];
          urs   <= wr_data_i[6];
        end
        for (int i = 0; i < NCH; i++)
          if (wr_addr_i == ADDR_W'(2 + i)) cmp[i] <= wr_data_i[CNT_W-1:0];
      end
      if (upd_i) end_act <= end_sh;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      running <= 1'b0; cnt <= '0; pc <= '0;
    end else if (start) begin
      running <= 1'b1; cnt <= '0; pc <= '0;
    end else if (upd_i) begin
      cnt <= '0; pc <= '0;
    end else if (running) begin
      if (tick) begin
        pc <= '0;
        if (last) begin
          cnt <= '0;
          running <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        pc <= pc + PSC_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ier <= '0; flag <= '0; uflag <= 1'b0;
    end else begin
      if (wr_irq) begin
        ier <= ier | wr_data_i[NCH-1:0];
        if (wr_data_i[NCH]) begin
          flag  <= '0;
          uflag <= 1'b0;
        end
      end
      if ((upd_i && !urs) || ovf) uflag <= 1'b1;
      for (int i = 0; i < NCH; i++)
        if (match[i] && ier[i]) begin
          flag[i] <= 1'b1;
          ier[i]  <= 1'b0;
        end
    end

  assign cmp_irq_o = flag;
  assign upd_irq_o = uflag;
  assign busy_o    = running;
  assign cnt_o     = cnt;

  assert_start_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> cnt == '0);

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> cnt == '0);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt <= end_act);

  assert_plain_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !rmode && trig_evt && !last) |=> running);

  assert_quiet_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && urs && !running) |=> !$rose(uflag));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> ($past(ier[i]) && !ier[i]));
  end
endmodule

// File: tb/oneshot_delay_timer_tb_top.sv
module oneshot_delay_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, e = 1'b0;
  logic wr_en = 1'b0, upd = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] cmp_irq;
  logic upd_irq, busy;
  logic [15:0] cnt;
  int total = 0, fails = 0;
  int seen = 0, fcnt = 0;

  always #2 clk = ~clk;

  oneshot_delay_timer dut_i (
    .clk(clk), .rst_n(rst_n), .trig_c1_i(a), .trig_c2_i(b), .trig_ext_i(e),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .upd_i(upd),
    .cmp_irq_o(cmp_irq), .upd_irq_o(upd_irq), .busy_o(busy), .cnt_o(cnt));

  // sel(2) pol{ext,c2,c1}(3) pin(2) level(1) psc(4) end(8) cmp(8) starts(1)
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 3'b000, 2'd0, 1'b1, 4'd0, 8'd3, 8'd2, 1'b1},
    {2'd0, 3'b000, 2'd0, 1'b0, 4'd1, 8'd2, 8'd0, 1'b1},
    {2'd1, 3'b001, 2'd0, 1'b1, 4'd0, 8'd4, 8'd1, 1'b0},
    {2'd1, 3'b001, 2'd0, 1'b0, 4'd0, 8'd5, 8'd5, 1'b1},
    {2'd2, 3'b000, 2'd1, 1'b1, 4'd2, 8'd1, 8'd1, 1'b1},
    {2'd2, 3'b000, 2'd0, 1'b1, 4'd0, 8'd3, 8'd1, 1'b0},
    {2'd3, 3'b100, 2'd2, 1'b1, 4'd0, 8'd3, 8'd1, 1'b0},
    {2'd3, 3'b100, 2'd2, 1'b0, 4'd0, 8'd0, 8'd0, 1'b1},
    {2'd3, 3'b000, 2'd2, 1'b1, 4'd3, 8'd2, 8'd2, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ad, input int d);
    wr_en = 1'b1; wr_addr = ad[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic run_count(output int n);
    n = 0;
    while (busy && n < 100000) begin
      if (cmp_irq[0] && seen == 0) begin seen = 1; fcnt = cnt; end
      n++;
      @(negedge clk);
    end
  endtask

  task automatic fire_a(output int n);
    a = ~a;
    repeat (3) @(negedge clk);
    run_count(n);
    repeat (2) @(negedge clk);
  endtask

  task automatic retrig(input bit use_upd, output int n);
    int c;
    a = ~a;
    repeat (3) @(negedge clk);
    repeat (5) @(negedge clk);
    if (use_upd) strobe(); else a = ~a;
    if (use_upd) begin run_count(c); n = 6 + c; end
    else begin run_count(c); n = 5 + c; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1 busy", busy, 0);
    check(cnt == 0, "R1 cnt", cnt, 0);
    check(cmp_irq == 0, "R1 cmp_irq", cmp_irq, 0);
    check(upd_irq == 0, "R1 upd_irq", upd_irq, 0);

    for (int v = 0; v < NV; v++) begin
      logic [28:0] w;
      int exp_len;
      w = VEC[v];
      wr(6, 64 | {w[26:24], w[28:27]});
      wr(0, w[20:17]);
      wr(1, w[16:9]);
      strobe();
      wr(2, w[8:1]);
      wr(7, 16 | 1);
      seen = 0;
      case (w[23:22])
        2'd0: a = w[21];
        2'd1: b = w[21];
        default: e = w[21];
      endcase
      repeat (3) @(negedge clk);
      check(busy == w[0], "R2/R3 start vs select/polarity", busy, w[0]);
      if (w[0]) begin
        check(cnt == 0, "R4 starts at zero", cnt, 0);
        run_count(n);
        exp_len = (w[16:9] + 1) * (w[20:17] + 1);
        check(n == exp_len, "R4/R5 run length", n, exp_len);
        check(seen == 1 && fcnt == w[8:1], "R6 flag at delay", fcnt, w[8:1]);
        check(upd_irq == 1, "R11 end sets update flag", upd_irq, 1);
        check(cnt == 0, "R4 idle holds zero", cnt, 0);
      end else begin
        repeat (6) @(negedge clk);
        check(busy == 0 && cnt == 0, "R2/R3 no start", busy, 0);
        check(cmp_irq == 0, "R6 nothing raised", cmp_irq, 0);
      end
      repeat (2) @(negedge clk);
    end

    wr(0, 0);
    wr(6, 0);
    wr(7, 16);
    wr(1, 7);
    strobe();
    check(upd_irq == 1, "R10 loud update", upd_irq, 1);
    wr(7, 16);
    wr(6, 64);
    strobe();
    check(upd_irq == 0, "R10 quiet update", upd_irq, 0);
    fire_a(n);
    check(n == 8, "R10 loaded end", n, 8);
    wr(1, 2);
    fire_a(n);
    check(n == 8, "R10 staged write alone", n, 8);

    wr(3, 3);
    wr(7, 16 | 2);
    fire_a(n);
    check(cmp_irq == 4'b0010, "R6 channel 1 raised", cmp_irq, 2);
    wr(7, 16);
    check(cmp_irq == 0, "R7 clear flags", cmp_irq, 0);
    fire_a(n);
    check(cmp_irq == 0, "R6 disarmed after match", cmp_irq, 0);
    wr(7, 2);
    fire_a(n);
    check(cmp_irq == 4'b0010, "R7 re-arm", cmp_irq, 2);

    wr(1, 20);
    strobe();
    retrig(1'b0, n);
    check(n == 21, "R8 retrigger ignored", n, 21);
    wr(6, 64 | 32);
    retrig(1'b0, n);
    check(n == 29, "R9 retrigger restarts", n, 29);
    wr(6, 64);
    retrig(1'b1, n);
    check(n == 27, "R10 update mid-run clears count", n, 27);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule